// File: doc/BRIEF.md
# Latency-Hiding Warp Issue Scheduler

This block picks, once per issue slot, one eligible warp from a pool of resident warps and sends that warp's next instruction to a shared execution pipeline. The pipeline is busy for a fixed number of cycles per instruction, so a new slot opens every `ISSUE_CYCLES` cycles. A different warp can take the very next slot at no cost. A warp that issues a memory load is parked for the full memory latency, and other warps fill the slots while it waits. Each warp has its own program counter and lane mask, and reads its program from a small opcode table fixed at elaboration.

When the lanes of a warp disagree on a branch, the warp first runs the fall-through path with only the lanes whose condition is clear. It then runs the branch-target path with only the lanes whose condition is set. At the join point it continues with its original mask. A stall counter records the cycles in which unfinished warps exist but none of them can issue.

Top module: `warp_issue_sched`

## Requirements
- R1: While reset is held, `iss_valid` is 0 and `stall_cycles` is 0. After reset every warp starts at PC 0 with all lanes enabled, and warp 0 issues first.
- R2: Issues happen only at slot boundaries, one every `ISSUE_CYCLES` cycles. Two strobes are never in adjacent cycles.
- R3: An eligible warp is resident, has not finished, and is not parked. Selection is round-robin among eligible warps, starting with the warp after the one that issued last.
- R4: Switching warps costs nothing: a different warp can issue exactly `ISSUE_CYCLES` cycles after the previous issue.
- R5: A LOAD (type 1) parks its warp. The warp's next issue comes at least `MEM_LAT` and at most `MEM_LAT + ISSUE_CYCLES` cycles after the LOAD issue.
- R6: Instruction word: bits [2*PC_W+1:2*PC_W] hold the type (0 ALU, 1 LOAD, 2 BRANCH, 3 END), bits [2*PC_W-1:PC_W] hold the join PC, and bits [PC_W-1:0] hold the target PC. A BRANCH whose lanes disagree behaves as follows:
  - The warp first issues from PC+1 with mask `mask & ~cond`, until its next PC would equal the target.
  - It then issues from the target with mask `mask & cond`, until its next PC would equal the join PC.
  - It then issues from the join PC with the mask it had before the branch.
  - One level of pending divergence is supported.
- R7: A BRANCH on which all active lanes agree creates no extra pass. If every active lane has its condition set, the warp goes to the target PC. If every active lane has it clear, the warp goes to PC+1. The mask is unchanged in both cases.
- R8: Lane numbering is global. Bit `w*LANES + i` of `br_cond` is the condition of lane `i` of warp `w`, and warp `w` ignores the bits of other warps.
- R9: An END (type 3) is issued once, after which the warp never issues again. A warp whose `resident` bit is 0 never issues.
- R10: `stall_cycles` increments in every cycle in which no warp is eligible while some resident warp is unfinished. It does not change when every warp is finished, and stays 0 when the resident warps never load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| resident | input | NUM_WARPS | Per-warp residency enable |
| br_cond | input | NUM_WARPS*LANES | Per-lane branch condition, warp-major |
| iss_valid | output | 1 | One-cycle issue strobe |
| iss_warp | output | max(1,clog2(NUM_WARPS)) | Warp that issued |
| iss_pc | output | PC_W | PC of the issued instruction |
| iss_mask | output | LANES | Lane mask of the issued instruction |
| stall_cycles | output | STALL_W | Count of cycles with no eligible warp |

## Verification
Two events can fall in the same slot. One is a divergence path switch: the not-taken pass reaches the target PC and the mask flips. The other is the round-robin pointer passing the next slot to another warp. The bench provokes this with a divergent warp interleaved with two compute warps. The scoreboard then expects, slot by slot, the flipped mask on the diverged warp and strict 4-cycle spacing across the warp change. A second pairing is a park expiring while the stall counter is running. The bench judges this by the returning warp's gap from its LOAD and by a stall count that is non-zero and frozen once all warps end.

// File: rtl/wsched_pkg.sv
package wsched_pkg;
   typedef enum logic [1:0] {
      OP_ALU    = 2'd0,
      OP_LOAD   = 2'd1,
      OP_BRANCH = 2'd2,
      OP_END    = 2'd3
   } op_e;
endpackage

// File: rtl/wsched_slot_timer.sv
module wsched_slot_timer #(
   parameter int ISSUE_CYCLES = 4
) (
   input  logic clk,
   input  logic rst_n,
   output logic slot
);
   localparam int CW = (ISSUE_CYCLES > 2) ? $clog2(ISSUE_CYCLES) : 1;

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n)                             cnt_q <= '0;
      else if (cnt_q == CW'(ISSUE_CYCLES-1))  cnt_q <= '0;
      else                                    cnt_q <= cnt_q + 1'b1;
   end

   assign slot = (cnt_q == '0);
endmodule

// File: rtl/wsched_rr_pick.sv
module wsched_rr_pick #(
   parameter int NUM_WARPS = 4,
   parameter int WID_W     = 2
) (
   input  logic [NUM_WARPS-1:0] req,
   input  logic [WID_W-1:0]     last,
   output logic                 gvalid,
   output logic [WID_W-1:0]     gidx
);
   function automatic int wrap_idx(input int v);
      return (v >= NUM_WARPS) ? v - NUM_WARPS : v;
   endfunction

   // walk from farthest to nearest so the warp right after 'last' wins
   always_comb begin
      gvalid = 1'b0;
      gidx   = '0;
      for (int k = NUM_WARPS; k >= 1; k--) begin
         if (req[wrap_idx(int'(last) + k)]) begin
            gvalid = 1'b1;
            gidx   = WID_W'(wrap_idx(int'(last) + k));
         end
      end
   end
endmodule

// File: rtl/wsched_warp_ctx.sv
module wsched_warp_ctx
   import wsched_pkg::*;
#(
   parameter int LANES   = 32,
   parameter int PC_W    = 3,
   parameter int MEM_LAT = 200,
   parameter int IW      = 2 + 2*PC_W,
   parameter int PLEN    = 1 << PC_W,
   parameter logic [PLEN*IW-1:0] PROG = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             resident,
   input  logic             issue_en,
   input  logic [LANES-1:0] cond,
   output logic             ready,
   output logic             done,
   output logic [PC_W-1:0]  pc_o,
   output logic [LANES-1:0] mask_o
);
   localparam int LW = $clog2(MEM_LAT + 1);

   logic [PC_W-1:0]  pc_q, tgt_q, join_q;
   logic [LANES-1:0] mask_q, tmask_q, fmask_q;
   logic [LW-1:0]    park_q;
   logic             end_q, div_q, phase_q;

   logic [IW-1:0]    instr;
   op_e              op;
   logic [PC_W-1:0]  f_tgt, f_join, np;
   logic [LANES-1:0] tk, nt;
   logic             diverge;

   assign instr  = PROG[int'(pc_q)*IW +: IW];
   assign op     = op_e'(instr[IW-1 -: 2]);
   assign f_join = instr[2*PC_W-1:PC_W];
   assign f_tgt  = instr[PC_W-1:0];
   assign tk     = mask_q & cond;
   assign nt     = mask_q & ~cond;

   always_comb begin
      np      = pc_q + 1'b1;
      diverge = 1'b0;
      if (op == OP_BRANCH) begin
         if (tk == '0)      np = pc_q + 1'b1;
         else if (nt == '0) np = f_tgt;
         else               diverge = 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pc_q    <= '0;
         mask_q  <= '1;
         park_q  <= '0;
         end_q   <= 1'b0;
         div_q   <= 1'b0;
         phase_q <= 1'b0;
         tgt_q   <= '0;
         join_q  <= '0;
         tmask_q <= '0;
         fmask_q <= '0;
      end else begin
         if (park_q != '0) park_q <= park_q - 1'b1;
         if (issue_en) begin
            if (op == OP_END)  end_q  <= 1'b1;
            if (op == OP_LOAD) park_q <= LW'(MEM_LAT);
            if (op != OP_END) begin
               if (diverge) begin
                  pc_q    <= np;
                  mask_q  <= nt;
                  div_q   <= 1'b1;
                  phase_q <= 1'b0;
                  tgt_q   <= f_tgt;
                  join_q  <= f_join;
                  tmask_q <= tk;
                  fmask_q <= mask_q;
               end else if (div_q && !phase_q && np == tgt_q) begin
                  pc_q    <= tgt_q;
                  mask_q  <= tmask_q;
                  phase_q <= 1'b1;
               end else if (div_q && phase_q && np == join_q) begin
                  pc_q    <= join_q;
                  mask_q  <= fmask_q;
                  div_q   <= 1'b0;
               end else begin
                  pc_q    <= np;
               end
            end
         end
      end
   end

   assign ready  = resident && !end_q && (park_q == '0);
   assign done   = !resident || end_q;
   assign pc_o   = pc_q;
   assign mask_o = mask_q;

   assert_park_blocks_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (park_q != '0) |-> !issue_en);
   assert_end_final_R9: assert property (@(posedge clk) disable iff (!rst_n)
      end_q |-> !issue_en);
   assert_live_mask_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (resident && !end_q) |-> (mask_q != '0));
   assert_rejoin_full_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(div_q) |-> (mask_q == $past(fmask_q)));
endmodule

// File: rtl/warp_issue_sched.sv
module warp_issue_sched #(
   parameter int NUM_WARPS    = 4,
   parameter int LANES        = 32,
   parameter int PC_W         = 3,
   parameter int ISSUE_CYCLES = 4,
   parameter int MEM_LAT      = 200,
   parameter int STALL_W      = 16,
   parameter logic [NUM_WARPS*(1<<PC_W)*(2+2*PC_W)-1:0] PROGRAM =
      {(NUM_WARPS*(1<<PC_W)){{2'b11, {(2*PC_W){1'b0}}}}}
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic [NUM_WARPS-1:0]         resident,
   input  logic [NUM_WARPS*LANES-1:0]   br_cond,
   output logic                         iss_valid,
   output logic [((NUM_WARPS > 1) ? $clog2(NUM_WARPS) : 1)-1:0] iss_warp,
   output logic [PC_W-1:0]              iss_pc,
   output logic [LANES-1:0]             iss_mask,
   output logic [STALL_W-1:0]           stall_cycles
);
   localparam int WID_W = (NUM_WARPS > 1) ? $clog2(NUM_WARPS) : 1;
   localparam int IW    = 2 + 2*PC_W;
   localparam int PLEN  = 1 << PC_W;
   localparam int WPROG = PLEN * IW;

   if (ISSUE_CYCLES < 2) begin : g_bad_slot
      $error("ISSUE_CYCLES must be at least 2");
   end
   if (MEM_LAT < 1) begin : g_bad_lat
      $error("MEM_LAT must be at least 1");
   end
   if (NUM_WARPS < 1 || PC_W < 1 || LANES < 1) begin : g_bad_dim
      $error("NUM_WARPS, PC_W and LANES must be positive");
   end

   logic [NUM_WARPS-1:0] ready, done;
   logic [PC_W-1:0]      pc_arr   [NUM_WARPS];
   logic [LANES-1:0]     mask_arr [NUM_WARPS];
   logic                 slot, gvalid, fire;
   logic [WID_W-1:0]     gidx, last_q;

   wsched_slot_timer #(.ISSUE_CYCLES(ISSUE_CYCLES)) u_slot (
      .clk(clk), .rst_n(rst_n), .slot(slot));

   wsched_rr_pick #(.NUM_WARPS(NUM_WARPS), .WID_W(WID_W)) u_pick (
      .req(ready), .last(last_q), .gvalid(gvalid), .gidx(gidx));

   assign fire = slot && gvalid;

   for (genvar w = 0; w < NUM_WARPS; w++) begin : g_warp
      wsched_warp_ctx #(
         .LANES(LANES), .PC_W(PC_W), .MEM_LAT(MEM_LAT), .IW(IW), .PLEN(PLEN),
         .PROG(PROGRAM[w*WPROG +: WPROG])
      ) u_ctx (
         .clk(clk), .rst_n(rst_n),
         .resident(resident[w]),
         .issue_en(fire && (gidx == WID_W'(w))),
         .cond(br_cond[w*LANES +: LANES]),
         .ready(ready[w]), .done(done[w]),
         .pc_o(pc_arr[w]), .mask_o(mask_arr[w]));
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         last_q       <= WID_W'(NUM_WARPS-1);
         iss_valid    <= 1'b0;
         iss_warp     <= '0;
         iss_pc       <= '0;
         iss_mask     <= '0;
         stall_cycles <= '0;
      end else begin
         iss_valid <= fire;
         if (fire) begin
            last_q   <= gidx;
            iss_warp <= gidx;
            iss_pc   <= pc_arr[gidx];
            iss_mask <= mask_arr[gidx];
         end
         if (!(|ready) && !(&done)) stall_cycles <= stall_cycles + 1'b1;
      end
   end

   assert_issue_spacing_R2: assert property (@(posedge clk) disable iff (!rst_n)
      iss_valid |=> !iss_valid);
   assert_grant_ready_R3: assert property (@(posedge clk) disable iff (!rst_n)
      fire |-> ready[gidx]);
   assert_no_stall_on_issue_R10: assert property (@(posedge clk) disable iff (!rst_n)
      iss_valid |-> $stable(stall_cycles));
endmodule

// File: tb/sim_warp_issue_sched.sv
`timescale 1ns/1ps
module sim_warp_issue_sched;
   localparam int NW = 4, LN = 32, PCW = 3, ISS = 4, LAT = 200;
   localparam logic [31:0] FM = 32'hFFFF_FFFF;

   function automatic logic [255:0] build_prog();
      logic [255:0] p;
      p = '0;
      for (int w = 0; w < NW; w++) begin
         for (int i = 0; i < 8; i++) begin
            logic [7:0] ins;
            ins = (i == 7) ? 8'hC0 : 8'h00;
            if (w == 0 && i == 1) ins = 8'hB4;       // branch, join 6, target 4
            if (w == 1 && i == 0) ins = 8'h40;       // load
            if (w == 1 && i >= 2) ins = 8'hC0;       // end
            p[(w*8+i)*8 +: 8] = ins;
         end
      end
      return p;
   endfunction

   localparam logic [255:0] PROG = build_prog();

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic [NW-1:0]  resident = '0;
   logic [NW*LN-1:0] br_cond = '0;
   logic           iss_valid;
   logic [1:0]     iss_warp;
   logic [PCW-1:0] iss_pc;
   logic [LN-1:0]  iss_mask;
   logic [15:0]    stall_cycles;

   warp_issue_sched #(.NUM_WARPS(NW), .LANES(LN), .PC_W(PCW), .ISSUE_CYCLES(ISS),
      .MEM_LAT(LAT), .STALL_W(16), .PROGRAM(PROG)) u0 (
      .clk(clk), .rst_n(rst_n), .resident(resident), .br_cond(br_cond),
      .iss_valid(iss_valid), .iss_warp(iss_warp), .iss_pc(iss_pc),
      .iss_mask(iss_mask), .stall_cycles(stall_cycles));

   always #2.5 clk = ~clk;

   typedef struct {
      int          warp;
      int          pc;
      logic [31:0] mask;
      int          gap;
      bit          after_load;
      string       tag;
   } item_t;

   item_t q[$];
   int checks = 0, errors = 0;
   longint cyc = 0, last_cyc = 0;
   longint warp_last[NW];
   bit finished = 0;

   always @(posedge clk) cyc++;

   task automatic chk(bit ok, string req, string what, longint act, longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic push(int w, int pc, logic [31:0] m, int gap, bit ld, string tag);
      item_t it;
      it.warp = w; it.pc = pc; it.mask = m; it.gap = gap; it.after_load = ld; it.tag = tag;
      q.push_back(it);
   endtask

   // monitor: pops expected issues and compares
   always @(negedge clk) begin
      if (rst_n && iss_valid) begin
         if (q.size() == 0) begin
            checks++; errors++;
            $display("FAIL R9 unexpected issue actual warp %0d pc %0d expected none",
                     iss_warp, iss_pc);
         end else begin
            item_t it;
            it = q.pop_front();
            checks++;
            if (int'(iss_warp) != it.warp || int'(iss_pc) != it.pc || iss_mask != it.mask) begin
               errors++;
               $display("FAIL %s issue actual w%0d pc%0d m%h expected w%0d pc%0d m%h",
                        it.tag, iss_warp, iss_pc, iss_mask, it.warp, it.pc, it.mask);
            end
            if (it.gap > 0)
               chk(cyc - last_cyc == it.gap, "R4", "slot gap", cyc - last_cyc, it.gap);
            if (it.after_load) begin
               longint g;
               g = cyc - warp_last[it.warp];
               chk(g >= LAT && g <= LAT + ISS, "R5", "park gap", g, LAT);
            end
         end
         last_cyc = cyc;
         warp_last[iss_warp] = cyc;
      end
   end

   task automatic do_reset(logic [NW-1:0] res, logic [NW*LN-1:0] cnd);
      @(negedge clk);
      rst_n = 1'b0;
      resident = res;
      br_cond = cnd;
      repeat (3) @(negedge clk);
      chk(iss_valid == 1'b0, "R1", "valid in reset", iss_valid, 0);
      chk(stall_cycles == 0, "R1", "stall in reset", stall_cycles, 0);
   endtask

   task automatic run_and_drain();
      int t;
      rst_n = 1'b1;
      t = 0;
      while (q.size() != 0 && t < 2000) begin
         @(negedge clk);
         t++;
      end
      chk(q.size() == 0, "R3", "items left", q.size(), 0);
   endtask

   initial begin
      logic [31:0] w0m [8];
      int pcs [5];
      longint s0;

      // Scenario A: divergent warp 0, loading warp 1, two compute warps
      do_reset(4'b1111, {32'h1234_5678, 32'h0F0F_F0F0, 32'hA5A5_5A5A, 32'h0000_FFFF});
      w0m = '{FM, FM, 32'hFFFF_0000, 32'hFFFF_0000, 32'h0000_FFFF, 32'h0000_FFFF, FM, FM};
      push(0, 0, FM, 0, 0, "R1");
      push(1, 0, FM, 4, 0, "R3");
      push(2, 0, FM, 4, 0, "R3");
      push(3, 0, FM, 4, 0, "R3");
      for (int r = 1; r < 8; r++) begin
         push(0, r, w0m[r], 4, 0, "R6 R8");
         push(2, r, FM, 4, 0, "R3");
         push(3, r, FM, 4, 0, "R3");
      end
      push(1, 1, FM, 0, 1, "R5");
      push(1, 2, FM, 4, 0, "R9");
      run_and_drain();
      chk(stall_cycles > 0, "R10", "stall after load gap", stall_cycles, 1);
      s0 = stall_cycles;
      repeat (60) @(negedge clk);
      chk(stall_cycles == s0, "R10", "stall frozen when done", stall_cycles, s0);

      // Scenario B: warp 1 absent, warp 0 branch uniformly taken
      do_reset(4'b1101, {32'h0, 32'h0, 32'h0, 32'hFFFF_FFFF});
      pcs = '{1, 4, 5, 6, 7};
      push(0, 0, FM, 0, 0, "R1");
      push(2, 0, FM, 4, 0, "R9");
      push(3, 0, FM, 4, 0, "R3");
      for (int i = 0; i < 7; i++) begin
         if (i < 5) push(0, pcs[i], FM, 4, 0, "R7");
         push(2, i + 1, FM, 4, 0, "R3");
         push(3, i + 1, FM, 4, 0, "R3");
      end
      run_and_drain();
      repeat (60) @(negedge clk);
      chk(stall_cycles == 0, "R10", "no stall without loads", stall_cycles, 0);

      // Scenario C: warps 0 and 1, warp 0 branch uniformly not taken
      do_reset(4'b0011, {32'h0, 32'h0, 32'hFFFF_FFFF, 32'h0});
      push(0, 0, FM, 0, 0, "R1");
      push(1, 0, FM, 4, 0, "R3");
      for (int r = 1; r < 8; r++) push(0, r, FM, 4, 0, "R7");
      push(1, 1, FM, 0, 1, "R5");
      push(1, 2, FM, 4, 0, "R9");
      run_and_drain();
      repeat (60) @(negedge clk);
      chk(stall_cycles > 0, "R10", "stall with lone loader", stall_cycles, 1);

      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         checks++; errors++;
         $display("FAIL watchdog actual timeout expected completion");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule